// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block moves a processor subsystem between normal execution and three low-power states: a light sleep, a deep software-entered standby and a pin-forced hardware standby. One sleep strobe from the CPU leads to either light sleep or deep standby, chosen by a bit in a small control register. The block drives clock enables for the CPU and the peripherals, a CPU halt line, a one-cycle peripheral initialize pulse, a pin float control and a RAM-retention flag.

Each low-power state has its own set of wake sources. Light sleep ends on any wake request. Deep standby ends only on a non-maskable interrupt or a power-on reset. The active-low hardware standby pin takes precedence over every other input. Once that pin has gone high again, the block still waits for a power-on reset before it resumes. All wake requests and the standby pin pass through a two-stage synchronizer before the state machine uses them. The mode is entered one cycle after the strobe, so that an instruction already in flight can finish.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After reset the outputs are in the run pattern: cpu_clk_en=1, periph_clk_en=1, cpu_halt=0, pin_hiz=0, ram_retain=1, periph_init=0. The control register reads 0.
- R2: A bus write (bus_sel=1, bus_we=1) stores bus_wdata[0] as the deep-standby enable and bus_wdata[1] as the pin float enable. bus_rdata returns both bits combinationally, in the same bit positions, and reads 0 in bits 7:2. A write attempt with bus_we=0 changes nothing.
- R3: A sleep strobe with enable bit 0 gives the light-sleep pattern two clock edges later: cpu_clk_en=0, periph_clk_en=1, cpu_halt=1, pin_hiz=0, ram_retain=1.
- R4: A sleep strobe with enable bit 1 gives the deep-standby pattern two edges later: cpu_clk_en=0, periph_clk_en=0, cpu_halt=1, ram_retain=1, and pin_hiz equal to the float bit.
- R5: periph_init is high for exactly one cycle, which is the first cycle of deep standby. It is never high in any other state.
- R6: In light sleep, any of irq_req, nmi_req, dma_err_req, por_req or mrst_req held high restores the run pattern three edges after it rises.
- R7: In deep standby only nmi_req or por_req wakes the block. irq_req, dma_err_req and mrst_req leave it in deep standby.
- R8: hw_stby_n held low gives the hardware-standby pattern three edges later, from any state: cpu_clk_en=0, periph_clk_en=0, cpu_halt=1, pin_hiz=1, ram_retain=0. Strobes and wake requests have no effect while the pin is low.
- R9: After hw_stby_n returns high, the hardware-standby pattern stays until por_req is seen. The run pattern follows three edges after por_req rises. Other wake requests are ignored in this phase.
- R10: The low-power entry is abandoned, and the block stays in run, if a wake source that would end the target mode is pending when the strobe arrives or during the entry cycle.
- R11: In the cycle after the strobe the outputs still show the run pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_strobe | input | 1 | One-cycle sleep request from the CPU |
| hw_stby_n | input | 1 | Asynchronous hardware standby pin, active low |
| irq_req | input | 1 | Enabled maskable interrupt request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| dma_err_req | input | 1 | DMA address error event |
| por_req | input | 1 | Power-on reset request |
| mrst_req | input | 1 | Manual reset request |
| bus_sel | input | 1 | Control register select |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| cpu_halt | output | 1 | CPU halt |
| periph_init | output | 1 | Peripheral register initialize pulse |
| pin_hiz | output | 1 | I/O pin float control |
| ram_retain | output | 1 | RAM contents retained |

## Verification
A mode entry is due two edges after the strobe edge. One edge goes into the entry cycle and one into the mode, so the bench checks the run pattern after the first edge and the mode pattern after the second. Every asynchronous input, whether a wake request or the standby pin, acts three edges after it changes: two edges for the synchronizer and one for the state register. The bench drives inputs on falling edges and samples exactly three rising edges later. After each release it waits three more edges before the next step, so that a stale synchronized request cannot abandon the next entry. The initialize pulse is sampled in the first and the second deep-standby cycles to show that it lasts one cycle.

// File: rtl/pwr_pkg.sv
// Shared types for the low-power mode sequencer.
// Assumes: the encodings are used inside the sequencer only.
package pwr_pkg;
    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_ENTER  = 3'd1,
        ST_SLEEP  = 3'd2,
        ST_DEEP   = 3'd3,
        ST_HWSTBY = 3'd4,
        ST_HWWAIT = 3'd5
    } pwr_state_t;

    localparam int WAKE_IRQ  = 0;
    localparam int WAKE_NMI  = 1;
    localparam int WAKE_DMA  = 2;
    localparam int WAKE_POR  = 3;
    localparam int WAKE_MRST = 4;
    localparam int WAKE_N    = 5;
endpackage

// File: rtl/pwr_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous levels.
// Assumes: each bit is a slow level, so bits need not be coherent with each other.
module pwr_sync #(
    parameter int               WIDTH   = 6,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    // Shift the raw levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pwr_ctrl_reg.sv
// Standby control register behind a simple synchronous bus.
// Assumes: a single register, with no address decode; reads are combinational.
module pwr_ctrl_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              deep_en,
    output logic              float_en
);
    localparam int PAD_W = DATA_W - 2;

    // Capture both control bits on a selected write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deep_en  <= 1'b0;
            float_en <= 1'b0;
        end else if (bus_sel && bus_we) begin
            deep_en  <= bus_wdata[0];
            float_en <= bus_wdata[1];
        end
    end

    assign bus_rdata = {{PAD_W{1'b0}}, float_en, deep_en};

    // Check that a write stores its data (R2).
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we) |=> (bus_rdata[1:0] == $past(bus_wdata[1:0])));
    // Check that bits outside the two control bits read as zero (R2).
    p_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:2] == '0);
endmodule

// File: rtl/pwr_fsm.sv
// Mode state machine: picks the target mode on a sleep strobe, waits one entry
// cycle, applies the per-mode wake rules, and lets the standby pin take over.
// Assumes: every input except sleep_strobe and the control bits is already synchronized.
module pwr_fsm
    import pwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_strobe,
    input  logic              deep_en,
    input  logic              float_en,
    input  logic              hw_n,
    input  logic [WAKE_N-1:0] wake,
    output logic              cpu_clk_en,
    output logic              periph_clk_en,
    output logic              cpu_halt,
    output logic              periph_init,
    output logic              pin_hiz,
    output logic              ram_retain
);
    pwr_state_t state, nxt;
    logic       tgt_deep;
    logic       wake_any, wake_deep, tgt_wake;

    // Which requests can end each kind of low-power mode.
    always_comb begin
        wake_any  = |wake;
        wake_deep = wake[WAKE_NMI] | wake[WAKE_POR];
        tgt_wake  = tgt_deep ? wake_deep : wake_any;
    end

    // Next-state choice; a low standby pin wins over everything.
    always_comb begin
        nxt = state;
        if (!hw_n) begin
            nxt = ST_HWSTBY;
        end else begin
            case (state)
                ST_RUN:    if (sleep_strobe && !(deep_en ? wake_deep : wake_any)) nxt = ST_ENTER;
                ST_ENTER:  nxt = tgt_wake ? ST_RUN : (tgt_deep ? ST_DEEP : ST_SLEEP);
                ST_SLEEP:  if (wake_any) nxt = ST_RUN;
                ST_DEEP:   if (wake_deep) nxt = ST_RUN;
                ST_HWSTBY: nxt = ST_HWWAIT;
                ST_HWWAIT: if (wake[WAKE_POR]) nxt = ST_RUN;
                default:   nxt = ST_RUN;
            endcase
        end
    end

    // State register, latched target mode and the entry initialize pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_RUN;
            tgt_deep    <= 1'b0;
            periph_init <= 1'b0;
        end else begin
            state       <= nxt;
            periph_init <= (nxt == ST_DEEP) && (state != ST_DEEP);
            if (state == ST_RUN && sleep_strobe) tgt_deep <= deep_en;
        end
    end

    // Decode the output pattern of each state.
    always_comb begin
        cpu_clk_en    = (state == ST_RUN) || (state == ST_ENTER);
        periph_clk_en = cpu_clk_en || (state == ST_SLEEP);
        cpu_halt      = !cpu_clk_en;
        ram_retain    = !((state == ST_HWSTBY) || (state == ST_HWWAIT));
        pin_hiz       = !ram_retain || ((state == ST_DEEP) && float_en);
    end

    // The initialize pulse marks only the first cycle of deep standby (R5).
    p_init_first_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        periph_init |-> (state == ST_DEEP && $past(state) != ST_DEEP));
    // A low pin forces hardware standby on the next edge (R8).
    p_pin_override_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_n |=> (state == ST_HWSTBY));
    // Deep standby ignores the maskable, DMA and manual requests (R7).
    p_deep_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEEP && hw_n && !wake[WAKE_NMI] && !wake[WAKE_POR]) |=> (state == ST_DEEP));
    // Any request ends light sleep (R6).
    p_sleep_wakes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && hw_n && wake_any) |=> (state == ST_RUN));
    // After the pin returns high, only power-on reset resumes (R9).
    p_hw_waits_por_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HWWAIT && hw_n && !wake[WAKE_POR]) |=> (state == ST_HWWAIT));
    // A pending relevant request abandons entry (R10).
    p_entry_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ENTER && hw_n && tgt_wake) |=> (state == ST_RUN));
endmodule

// File: rtl/pwr_mode_ctl.sv
// Top of the low-power mode sequencer: synchronizes the asynchronous inputs,
// holds the control register and runs the mode state machine.
// Assumes: sleep_strobe and the bus are synchronous to clk.
module pwr_mode_ctl
    import pwr_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_strobe,
    input  logic              hw_stby_n,
    input  logic              irq_req,
    input  logic              nmi_req,
    input  logic              dma_err_req,
    input  logic              por_req,
    input  logic              mrst_req,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cpu_clk_en,
    output logic              periph_clk_en,
    output logic              cpu_halt,
    output logic              periph_init,
    output logic              pin_hiz,
    output logic              ram_retain
);
    localparam int                SYNC_W   = WAKE_N + 1;
    localparam logic [SYNC_W-1:0] SYNC_RST = {1'b1, {WAKE_N{1'b0}}};

    logic [WAKE_N-1:0] raw_wake, s_wake;
    logic [SYNC_W-1:0] s_all;
    logic              deep_en, float_en;

    // Gather the wake requests in the package bit order.
    always_comb begin
        raw_wake            = '0;
        raw_wake[WAKE_IRQ]  = irq_req;
        raw_wake[WAKE_NMI]  = nmi_req;
        raw_wake[WAKE_DMA]  = dma_err_req;
        raw_wake[WAKE_POR]  = por_req;
        raw_wake[WAKE_MRST] = mrst_req;
    end

    pwr_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({hw_stby_n, raw_wake}), .q(s_all)
    );

    assign s_wake = s_all[WAKE_N-1:0];

    pwr_ctrl_reg #(.DATA_W(DATA_W)) u_reg (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .deep_en(deep_en), .float_en(float_en)
    );

    pwr_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sleep_strobe(sleep_strobe),
        .deep_en(deep_en), .float_en(float_en),
        .hw_n(s_all[SYNC_W-1]), .wake(s_wake),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .cpu_halt(cpu_halt),
        .periph_init(periph_init), .pin_hiz(pin_hiz), .ram_retain(ram_retain)
    );
endmodule

// File: tb/pwr_mode_ctl_bench.sv
`timescale 1ns/1ps
module pwr_mode_ctl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_strobe = 1'b0;
    logic       hw_stby_n = 1'b1;
    logic [4:0] wreq = '0;
    logic       bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cpu_clk_en, periph_clk_en, cpu_halt, periph_init, pin_hiz, ram_retain;
    int         checks = 0;
    int         errors = 0;

    // Wake bench order: 0 irq, 1 nmi, 2 dma error, 3 power-on reset, 4 manual reset.
    pwr_mode_ctl u_pwr_mode_ctl (
        .clk(clk), .rst_n(rst_n), .sleep_strobe(sleep_strobe), .hw_stby_n(hw_stby_n),
        .irq_req(wreq[0]), .nmi_req(wreq[1]), .dma_err_req(wreq[2]),
        .por_req(wreq[3]), .mrst_req(wreq[4]),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .cpu_halt(cpu_halt),
        .periph_init(periph_init), .pin_hiz(pin_hiz), .ram_retain(ram_retain)
    );

    always #10 clk = ~clk;

    // Pattern bits: {cpu_clk_en, periph_clk_en, cpu_halt, pin_hiz, ram_retain}.
    localparam logic [4:0] PAT_RUN   = 5'b11001;
    localparam logic [4:0] PAT_SLEEP = 5'b01101;
    localparam logic [4:0] PAT_HW    = 5'b00110;

    function automatic logic [4:0] pat_deep(input logic flt);
        return {3'b001, flt, 1'b1};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_pat(input string req, input logic [4:0] exp);
        chk(req, {3'b0, cpu_clk_en, periph_clk_en, cpu_halt, pin_hiz, ram_retain}, {3'b0, exp});
    endtask

    task automatic bus_write(input logic [7:0] v, input logic we);
        bus_sel = 1'b1; bus_we = we; bus_wdata = v;
        tick(1);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    // One-cycle strobe; afterwards the block is in its entry cycle.
    task automatic strobe();
        sleep_strobe = 1'b1;
        tick(1);
        sleep_strobe = 1'b0;
    endtask

    // Raise a request, wait for it to act, then release and let it drain.
    task automatic wake_pulse(input int idx);
        wreq[idx] = 1'b1;
        tick(3);
    endtask

    task automatic wake_release(input int idx);
        wreq[idx] = 1'b0;
        tick(3);
    endtask

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state.
        chk_pat("R1 reset outputs", PAT_RUN);
        chk("R1 init low", {7'b0, periph_init}, 8'h00);
        chk("R1 reg reset", bus_rdata, 8'h00);

        // R2: register access.
        bus_write(8'hFF, 1'b1);
        chk("R2 write ff", bus_rdata, 8'h03);
        bus_write(8'h00, 1'b0);
        chk("R2 no write without we", bus_rdata, 8'h03);
        bus_write(8'h02, 1'b1);
        chk("R2 write 02", bus_rdata, 8'h02);

        // Sweep every control value against every wake source.
        for (int cfg = 0; cfg < 4; cfg++) begin
            for (int src = 0; src < 5; src++) begin
                logic deep, flt, wakes;
                deep  = cfg[0];
                flt   = cfg[1];
                wakes = !deep || (src == 1) || (src == 3);
                bus_write(cfg[7:0], 1'b1);
                strobe();
                chk_pat("R11 run during entry", PAT_RUN);
                tick(1);
                chk_pat(deep ? "R4 deep entry" : "R3 sleep entry", deep ? pat_deep(flt) : PAT_SLEEP);
                chk("R5 init first cycle", {7'b0, periph_init}, {7'b0, deep});
                tick(1);
                chk("R5 init one cycle", {7'b0, periph_init}, 8'h00);
                wake_pulse(src);
                if (wakes)
                    chk_pat(deep ? "R7 deep wake" : "R6 sleep wake", PAT_RUN);
                else
                    chk_pat("R7 deep ignores request", pat_deep(flt));
                wake_release(src);
                if (!wakes) begin
                    chk_pat("R7 deep still held", pat_deep(flt));
                    wake_pulse(1);
                    chk_pat("R7 nmi wakes deep", PAT_RUN);
                    wake_release(1);
                end
                chk("R5 no init in run", {7'b0, periph_init}, 8'h00);
            end
        end

        // R10: a pending request abandons entry only if it would end the target mode.
        bus_write(8'h00, 1'b1);
        wake_pulse(0);
        strobe();
        tick(1);
        chk_pat("R10 irq abandons sleep", PAT_RUN);
        bus_write(8'h01, 1'b1);
        strobe();
        tick(1);
        chk_pat("R10 irq does not abandon deep", pat_deep(1'b0));
        wake_release(0);
        wake_pulse(1);
        chk_pat("R7 nmi after irq", PAT_RUN);
        strobe();
        tick(1);
        chk_pat("R10 nmi abandons deep", PAT_RUN);
        wake_release(1);

        // R8/R9: hardware standby from run, sleep and deep standby.
        for (int from = 0; from < 3; from++) begin
            bus_write((from == 2) ? 8'h03 : 8'h00, 1'b1);
            if (from != 0) begin
                strobe();
                tick(1);
            end
            hw_stby_n = 1'b0;
            tick(3);
            chk_pat("R8 hw standby entered", PAT_HW);
            wake_pulse(3);
            chk_pat("R8 por ignored while pin low", PAT_HW);
            strobe();
            chk_pat("R8 strobe ignored while pin low", PAT_HW);
            wake_release(3);
            hw_stby_n = 1'b1;
            tick(4);
            chk_pat("R9 halted after pin high", PAT_HW);
            wake_pulse(1);
            chk_pat("R9 nmi ignored", PAT_HW);
            wake_release(1);
            wake_pulse(3);
            chk_pat("R9 por resumes", PAT_RUN);
            wake_release(3);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule